// File: doc/BRIEF.md
# Serial Control-Command Register Responder

This block sits on the device side of a serial host link. It takes the register-access half of that link. A word shifter, which is not part of the block, delivers each 32-bit word received from the host with a one-cycle strobe. A chip-select level marks the frame. Each frame carries at most one command. The first word is a header that states the direction, the start address and the word count. The block then reads or writes a run of consecutive registers and auto-increments the address after each word. It loads one 32-bit response word per strobe, and the shifter sends that word to the host during the next word slot.

The register space is small. It holds a read-only identity word, a status word and a configurable number of read/write configuration words. The status word carries a header-error flag and a reset-complete flag. Both flags clear when software writes one to them. An address that decodes to none of these registers reads as zero and ignores writes.

The host paces the word interface and the block cannot stall it, so the input has no ready signal. A strobe is accepted in every cycle it is high. The response register changes only on an accepted strobe or when the frame ends.

Top module: `spi_ctl_responder`

## Requirements
- R1: The header bits are defined as follows: bit 31 is a data/control selector and must be 0, bit 29 is 1 for a write and 0 for a read, bits 23:8 are the start address, bits 7:1 hold the word count minus one, and bit 0 makes the total count of ones odd. When a header is accepted, it appears on `resp_word` after the edge that took it, which places it in the next word slot.
- R2: During a read, every host word after the header is ignored and changes no register. The response after data word k is the register at address start+k-1.
- R3: A command covers exactly count (field+1, so 1 to 128) words, and the address rises by one for each word, wrapping at 16 bits.
- R4: An address outside the map reads as zero. The map is: 0x0000 is the identity word 0x5A1C0001, 0x0001 is the status word (bit 0 header error, bit 1 reset complete), and 0x0002 to 0x0005 are configuration words.
- R5: During a write, data word k is stored at address start+k-1, and the same word is echoed back on `resp_word` after the edge that took it.
- R6: Once the counted words are done, any further words in the frame, including the trailing word, are ignored and answered with zero.
- R7: A write to an unmapped address or to the identity word has no effect.
- R8: Reset complete becomes 1 at the 16th clock edge after reset is released. It stays 1 until a write puts a one in status bit 1, and after that it never sets again.
- R9: A header with even parity and bit 31 at 0 sets the header-error flag. The command does not run, and every response for the rest of the frame is zero. A write of one to status bit 0 clears the flag.
- R10: A header with bit 31 at 1 is ignored for the whole frame. It has no effect on any register or flag, and every response is zero.
- R11: When `cs_active` goes low, the command in progress ends and `resp_word` returns to zero.
- R12: After reset, `resp_word` and all configuration words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High for the length of a host frame |
| word_valid | input | 1 | One-cycle strobe for a received word |
| word_in | input | 32 | Word received from the host |
| resp_word | output | 32 | Word to send in the next slot |

## Verification
The bench targets bursts that run past the end of the map. A design that did not zero-fill or guard its writes would return stale data or corrupt a neighbouring word there. It sends write commands with extra trailing words, which would catch an off-by-one count that writes one register too many. It sends read commands whose data slots carry nonzero host words, so a design that wrongly treated those words as writes would show the corruption on a later read-back. Other cases are a header with bad parity, a header with the selector bit set, an abort in the middle of a burst, and the set-once behaviour of the reset-complete flag before and after a write-one clear. A design that got any of these wrong would run the command, leave a flag at the wrong value, or keep sending stale responses after the frame ends.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 7;

  typedef struct packed {
    logic              dnc;
    logic              rsv30;
    logic              wnr;
    logic [4:0]        rsv;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len_m1;
    logic              par;
  } hdr_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} seq_state_e;
endpackage

// File: rtl/ctl_hdr_decode.sv
module ctl_hdr_decode
  import ctl_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  output hdr_t              hdr,
  output logic              par_ok
);
  assign hdr    = hdr_t'(word);
  assign par_ok = ^word;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_pkg::*;
#(
  parameter int          NCFG        = 4,
  parameter int          CFG_BASE    = 2,
  parameter int          ID_ADDR     = 0,
  parameter int          STATUS_ADDR = 1,
  parameter logic [31:0] ID_VALUE    = 32'h5A1C_0001,
  parameter int          RST_CYCLES  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hdr_err_set
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0]                boot_cnt;
  logic                         done_q, herr_q;
  logic [NCFG-1:0][DATA_W-1:0]  cfg_q;
  logic                         wr_status;

  function automatic logic is_cfg(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(CFG_BASE)) && (a < ADDR_W'(CFG_BASE + NCFG));
  endfunction

  assign wr_status = wr_en && (wr_addr == ADDR_W'(STATUS_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_cnt <= '0;
    else if (boot_cnt != CW'(RST_CYCLES)) boot_cnt <= boot_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      herr_q <= 1'b0;
    end else begin
      if (boot_cnt == CW'(RST_CYCLES - 1)) done_q <= 1'b1;
      else if (wr_status && wr_data[1]) done_q <= 1'b0;
      if (hdr_err_set) herr_q <= 1'b1;
      else if (wr_status && wr_data[0]) herr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) begin
      for (int i = 0; i < NCFG; i++)
        if (wr_addr == ADDR_W'(CFG_BASE + i)) cfg_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ID_ADDR)) rd_data = ID_VALUE;
    if (rd_addr == ADDR_W'(STATUS_ADDR)) rd_data = {{(DATA_W-2){1'b0}}, done_q, herr_q};
    for (int i = 0; i < NCFG; i++)
      if (rd_addr == ADDR_W'(CFG_BASE + i)) rd_data = cfg_q[i];
  end

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !(wr_status && wr_data[1]) |=> done_q);
  a_r9_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err_set |=> herr_q);
  a_r7_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !is_cfg(wr_addr) |=> $stable(cfg_q));
  a_r4_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cfg(rd_addr) && rd_addr != ADDR_W'(ID_ADDR) && rd_addr != ADDR_W'(STATUS_ADDR)
      |-> rd_data == '0);
endmodule

// File: rtl/ctl_cmd_seq.sv
module ctl_cmd_seq
  import ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              hdr_err_set,
  output logic [DATA_W-1:0] resp_word
);
  seq_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  hdr_t              hdr;
  logic              par_ok, take;

  ctl_hdr_decode u_dec (.word(word_in), .hdr(hdr), .par_ok(par_ok));

  assign take        = cs_active && word_valid;
  assign rd_addr     = addr_q;
  assign wr_addr     = addr_q;
  assign wr_data     = word_in;
  assign wr_en       = take && (st == S_WR);
  assign hdr_err_set = take && (st == S_IDLE) && !hdr.dnc && !par_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      left_q    <= '0;
      resp_word <= '0;
    end else if (!cs_active) begin
      st        <= S_IDLE;
      resp_word <= '0;
    end else if (word_valid) begin
      unique case (st)
        S_IDLE: begin
          if (hdr.dnc || !par_ok) begin
            st        <= S_DONE;
            resp_word <= '0;
          end else begin
            resp_word <= word_in;
            addr_q    <= hdr.addr;
            left_q    <= hdr.len_m1;
            st        <= hdr.wnr ? S_WR : S_RD;
          end
        end
        S_RD, S_WR: begin
          resp_word <= (st == S_RD) ? rd_data : word_in;
          addr_q    <= addr_q + 1'b1;
          if (left_q == '0) st <= S_DONE;
          else left_q <= left_q - 1'b1;
        end
        default: resp_word <= '0;
      endcase
    end
  end

  a_r2_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RD |-> !wr_en);
  a_r6_quiet_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DONE && take |=> resp_word == '0);
  a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    take && (st == S_RD || st == S_WR) |=> addr_q == $past(addr_q) + 1'b1);
  a_r9_bad_hdr_silent: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err_set |=> resp_word == '0 && st == S_DONE);
endmodule

// File: rtl/spi_ctl_responder.sv
module spi_ctl_responder
  import ctl_pkg::*;
#(
  parameter int          NCFG       = 4,
  parameter logic [31:0] ID_VALUE   = 32'h5A1C_0001,
  parameter int          RST_CYCLES = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_active,
  input  logic        word_valid,
  input  logic [31:0] word_in,
  output logic [31:0] resp_word
);
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, hdr_err_set;

  ctl_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .word_valid(word_valid),
    .word_in(word_in), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hdr_err_set(hdr_err_set),
    .resp_word(resp_word)
  );

  ctl_regfile #(
    .NCFG(NCFG), .CFG_BASE(2), .ID_ADDR(0), .STATUS_ADDR(1),
    .ID_VALUE(ID_VALUE), .RST_CYCLES(RST_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hdr_err_set(hdr_err_set)
  );

  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> resp_word == '0);
endmodule

// File: tb/sim_spi_ctl_responder.sv
module sim_spi_ctl_responder;
  localparam int          RSTC  = 16;
  localparam logic [31:0] IDV   = 32'h5A1C_0001;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, wv = 1'b0;
  logic [31:0] wi = '0, resp;
  always #5 clk = ~clk;

  spi_ctl_responder u0 (.clk(clk), .rst_n(rst_n), .cs_active(cs), .word_valid(wv),
                        .word_in(wi), .resp_word(resp));

  int compared = 0, mismatched = 0, wd = 0;
  string tag = "R12";
  logic [31:0] fq[$];

  // behavioural reference model
  logic [31:0] m_cfg [int];
  bit m_done, m_herr;
  int m_st, m_rem, m_edges;
  logic [15:0] m_addr;
  logic [31:0] exp_resp;

  function automatic logic [31:0] m_read(logic [15:0] a);
    if (a == 16'd0) return IDV;
    if (a == 16'd1) return {30'd0, m_done, m_herr};
    if (a >= 16'd2 && a <= 16'd5) return m_cfg[int'(a)];
    return 32'd0;
  endfunction

  function automatic void m_write(logic [15:0] a, logic [31:0] d);
    if (a == 16'd1) begin
      if (d[0]) m_herr = 0;
      if (d[1]) m_done = 0;
    end else if (a >= 16'd2 && a <= 16'd5) m_cfg[int'(a)] = d;
  endfunction

  function automatic logic [31:0] m_step(logic [31:0] w);
    logic [31:0] r;
    r = 32'd0;
    case (m_st)
      0: begin
        if (w[31]) m_st = 3;
        else if (!(^w)) begin m_herr = 1; m_st = 3; end
        else begin
          r = w; m_addr = w[23:8]; m_rem = int'(w[7:1]) + 1; m_st = w[29] ? 2 : 1;
        end
      end
      1, 2: begin
        if (m_st == 1) r = m_read(m_addr);
        else begin m_write(m_addr, w); r = w; end
        m_addr = m_addr + 16'd1;
        m_rem--;
        if (m_rem == 0) m_st = 3;
      end
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 2; i <= 5; i++) m_cfg[i] = 32'd0;
      m_done = 0; m_herr = 0; m_st = 0; m_edges = 0; exp_resp = 32'd0;
    end else begin
      if (!cs) begin m_st = 0; exp_resp = 32'd0; end
      else if (wv) exp_resp = m_step(wi);
      if (m_edges == RSTC - 1) m_done = 1;
      if (m_edges < RSTC) m_edges++;
    end
  end

  always @(negedge clk) begin
    compared++;
    if (resp !== exp_resp) begin
      mismatched++;
      $display("FAIL %s: resp_word actual %h expected %h at %0t", tag, resp, exp_resp, $time);
    end
  end

  function automatic logic [31:0] hdr(bit wr, logic [15:0] a, int n);
    logic [31:0] h;
    h = {1'b0, 1'b0, wr, 5'd0, a, 7'(n - 1), 1'b0};
    h[0] = ~(^h);
    return h;
  endfunction

  task automatic run_frame(input int gap, input int cut);
    @(negedge clk); cs = 1'b1;
    foreach (fq[i]) begin
      if (cut >= 0 && i == cut) break;
      wi = fq[i]; wv = 1'b1;
      @(negedge clk); wv = 1'b0; wi = $urandom;
      repeat (gap) @(negedge clk);
    end
    cs = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R8"; fq = {hdr(0, 16'd1, 1), 32'd0, 32'd0}; run_frame(0, -1);   // early: done still 0
    tag = "R5"; fq = {hdr(1, 16'd2, 1), 32'hCAFE_0002, 32'hFFFF_FFFF}; run_frame(1, -1);
    tag = "R6"; fq = {hdr(0, 16'd2, 2), 32'd0, 32'd0, 32'd0, 32'd0}; run_frame(0, -1);
    tag = "R3"; fq = {hdr(1, 16'd2, 4), 32'h11, 32'h22, 32'h33, 32'h44, 32'h99}; run_frame(0, -1);
    tag = "R4"; fq = {hdr(0, 16'd0, 8), 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 32'h8, 32'h9};
    run_frame(0, -1);
    tag = "R7"; fq = {hdr(1, 16'h0100, 2), 32'hDEAD, 32'hBEEF, 32'h0}; run_frame(0, -1);
    tag = "R7"; fq = {hdr(1, 16'd5, 3), 32'h55, 32'h66, 32'h77, 32'h0}; run_frame(0, -1);
    tag = "R7"; fq = {hdr(0, 16'd0, 7), 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
    run_frame(0, -1);
    tag = "R2"; fq = {hdr(0, 16'd2, 2), hdr(1, 16'd3, 1), 32'hABCD, 32'h1234}; run_frame(0, -1);
    tag = "R2"; fq = {hdr(0, 16'd2, 4), 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}; run_frame(2, -1);
    tag = "R9"; fq = {hdr(1, 16'd2, 1) ^ 32'h0000_0100, 32'h7777, 32'h0}; run_frame(0, -1);
    tag = "R9"; fq = {hdr(0, 16'd1, 1), 32'd0, 32'd0}; run_frame(0, -1);
    tag = "R9"; fq = {hdr(1, 16'd1, 1), 32'h1, 32'h0}; run_frame(0, -1);
    tag = "R8"; fq = {hdr(1, 16'd1, 1), 32'h2, 32'h0}; run_frame(0, -1);
    repeat (RSTC + 4) @(negedge clk);
    tag = "R8"; fq = {hdr(0, 16'd1, 1), 32'd0, 32'd0}; run_frame(0, -1);
    tag = "R10"; fq = {hdr(1, 16'd2, 1) | 32'h8000_0000, 32'h4444, 32'h0}; run_frame(0, -1);
    tag = "R10"; fq = {hdr(0, 16'd0, 6), 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}; run_frame(0, -1);
    tag = "R11"; fq = {hdr(1, 16'd2, 4), 32'hA1, 32'hA2, 32'hA3, 32'hA4, 32'h0}; run_frame(0, 2);
    tag = "R11"; fq = {hdr(0, 16'd2, 4), 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}; run_frame(0, -1);
    tag = "R1"; fq = {hdr(0, 16'hFFFF, 3), 32'd0, 32'd0, 32'd0, 32'd0}; run_frame(0, -1);
    tag = "R3"; fq = {hdr(1, 16'hFFFE, 5), 32'h1, 32'h2, 32'h3, 32'h4, 32'hB5, 32'h0}; run_frame(0, -1);
    tag = "R3"; fq = {hdr(0, 16'd0, 6), 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}; run_frame(0, -1);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule